// File: doc/BRIEF.md
# PLL digital lock detector

This block decides whether a phase-locked loop is in lock. It watches two divided-down clocks, the reference divider output and the feedback divider output. Both arrive asynchronously to a fast sampling clock. The block counts how many sample ticks separate their rising edges, and from those counts it drives a single lock indication. Every input and output is a plain control or status pin. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Every pair of rising edges produces one phase-error measurement, in whichever order the two edges arrive. If the second edge never arrives, a timeout ends the wait and records a saturated error. Most measurements are only counted. Every EVAL_PERIOD-th measurement is evaluated against two thresholds. Lock is declared only after GOOD_RUN consecutive evaluations below the lock threshold. A single evaluation above the unlock threshold withdraws lock at once. An enable pin and a power-down pin both force the output low and discard all progress. Lock must then be earned again from the beginning.

Top module: `pll_lock_detect`

## Requirements
- R1: Each divider input passes through a two-flop synchronizer. The measured error is the number of sample ticks between the synchronized rising edges, whichever edge leads. Coincident edges give an error of 0.
- R2: If the second edge has not arrived TIMEOUT_TICKS ticks after the first, the measurement ends with an error of exactly TIMEOUT_TICKS.
- R3: Only every EVAL_PERIOD-th completed measurement since reset or since the last clear is evaluated. The others leave the output unchanged.
- R4: lock_out rises only after GOOD_RUN consecutive evaluations, each with an error strictly below LOCK_TICKS.
- R5: A single evaluation with an error strictly above UNLOCK_TICKS drops lock_out and restarts the consecutive-good run.
- R6: An evaluated error from LOCK_TICKS through UNLOCK_TICKS leaves lock_out unchanged but restarts the consecutive-good run.
- R7: While lock_en is 0, lock_out is 0. Lock state, the good run and the measurement counter are cleared.
- R8: While pwr_down is 1, lock_out is 0, with the same clearing as R7.
- R9: After reset, lock_out is 0 and all counters are zero.
- R10: When a clear (R7 or R8) coincides with an evaluation that would complete a good run, the clear wins and no lock is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference divider output, asynchronous |
| fb_in | input | 1 | Feedback divider output, asynchronous |
| lock_en | input | 1 | Lock-detect enable; 0 forces the output low |
| pwr_down | input | 1 | Power-down; 1 forces the output low |
| lock_out | output | 1 | Lock indication, high when locked |

## Verification
Two actions can fall in the same cycle: clearing the detector through power-down or enable, and the evaluation that would complete a good run. The bench provokes this by leading the detector through GOOD_RUN*EVAL_PERIOD-1 good measurements. It then holds pwr_down high for the whole reference cycle that would finish the run. The result is judged correct only if lock_out stays low afterwards, and only if a full new run of good evaluations is needed before it rises. Every step is checked against an arithmetic model of the counters kept in the bench. A sweep of every phase offset from -12 to +12 ticks exercises each threshold band.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    PM_IDLE     = 2'd0,
    PM_WAIT_FB  = 2'd1,
    PM_WAIT_REF = 2'd2
  } pm_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/phase_meter.sv
module phase_meter
  import pll_lock_pkg::*;
#(
  parameter int ERR_W         = 5,
  parameter int TIMEOUT_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             meas_valid,
  output logic [ERR_W-1:0] meas_err
);
  localparam logic [ERR_W-1:0] TMO = ERR_W'(TIMEOUT_TICKS);

  pm_state_e        st;
  logic [ERR_W-1:0] cnt;
  logic             second_edge;

  assign second_edge = (st == PM_WAIT_FB) ? fb_rise : ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PM_IDLE;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
    end else begin
      meas_valid <= 1'b0;
      case (st)
        PM_IDLE: begin
          if (ref_rise && fb_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= '0;
          end else if (ref_rise) begin
            st  <= PM_WAIT_FB;
            cnt <= ERR_W'(1);
          end else if (fb_rise) begin
            st  <= PM_WAIT_REF;
            cnt <= ERR_W'(1);
          end
        end
        default: begin
          if (second_edge || cnt == TMO) begin
            meas_valid <= 1'b1;
            meas_err   <= cnt;
            st         <= PM_IDLE;
          end else begin
            cnt <= cnt + ERR_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm #(
  parameter int ERR_W        = 5,
  parameter int LOCK_TICKS   = 10,
  parameter int UNLOCK_TICKS = 10,
  parameter int GOOD_RUN     = 4,
  parameter int EVAL_PERIOD  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             meas_valid,
  input  logic [ERR_W-1:0] meas_err,
  output logic             eval_fire,
  output logic             locked
);
  localparam int EC_W = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam int GR_W = $clog2(GOOD_RUN + 1);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(EVAL_PERIOD - 1);
  localparam logic [GR_W-1:0] GR_MAX  = GR_W'(GOOD_RUN);

  logic [EC_W-1:0] eval_cnt;
  logic [GR_W-1:0] good_cnt;
  logic [GR_W-1:0] good_inc;
  logic            is_good;
  logic            is_bad;

  assign eval_fire = active && meas_valid && (eval_cnt == EC_LAST);
  assign is_good   = meas_err < ERR_W'(LOCK_TICKS);
  assign is_bad    = meas_err > ERR_W'(UNLOCK_TICKS);
  assign good_inc  = (good_cnt == GR_MAX) ? good_cnt : good_cnt + GR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_cnt <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (!active) begin
      eval_cnt <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (eval_fire) begin
      eval_cnt <= '0;
      if (is_bad) begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end else if (is_good) begin
        good_cnt <= good_inc;
        if (good_inc == GR_MAX) locked <= 1'b1;
      end else begin
        good_cnt <= '0;
      end
    end else if (meas_valid) begin
      eval_cnt <= eval_cnt + EC_W'(1);
    end
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int LOCK_TICKS    = 10,
  parameter int UNLOCK_TICKS  = 10,
  parameter int GOOD_RUN      = 4,
  parameter int EVAL_PERIOD   = 64,
  parameter int TIMEOUT_TICKS = 255,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic lock_en,
  input  logic pwr_down,
  output logic lock_out
);
  localparam int ERR_W = $clog2(TIMEOUT_TICKS + 1);

  logic [1:0]       raw_in;
  logic [1:0]       rise;
  logic             meas_valid;
  logic [ERR_W-1:0] meas_err;
  logic             eval_fire;
  logic             locked;
  logic             active;

  assign raw_in = {fb_in, ref_in};
  assign active = lock_en & ~pwr_down;

  for (genvar g = 0; g < 2; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (raw_in[g]),
      .rise (rise[g])
    );
  end

  phase_meter #(.ERR_W(ERR_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (rise[0]),
    .fb_rise   (rise[1]),
    .meas_valid(meas_valid),
    .meas_err  (meas_err)
  );

  lock_fsm #(
    .ERR_W(ERR_W), .LOCK_TICKS(LOCK_TICKS), .UNLOCK_TICKS(UNLOCK_TICKS),
    .GOOD_RUN(GOOD_RUN), .EVAL_PERIOD(EVAL_PERIOD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .meas_valid(meas_valid),
    .meas_err  (meas_err),
    .eval_fire (eval_fire),
    .locked    (locked)
  );

  assign lock_out = locked & active;
endmodule

// File: rtl/pll_lock_checker.sv
module pll_lock_checker #(
  parameter int ERR_W         = 5,
  parameter int LOCK_TICKS    = 10,
  parameter int UNLOCK_TICKS  = 10,
  parameter int TIMEOUT_TICKS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_en,
  input logic             pwr_down,
  input logic             lock_out,
  input logic             meas_valid,
  input logic [ERR_W-1:0] meas_err,
  input logic             eval_fire,
  input logic             locked
);
  a_r2_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> meas_err <= ERR_W'(TIMEOUT_TICKS));

  a_r3_change_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> ($past(eval_fire) || !$past(lock_en) || $past(pwr_down)));

  a_r4_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(eval_fire) && $past(meas_err) < ERR_W'(LOCK_TICKS)));

  a_r5_drop_on_big: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && meas_err > ERR_W'(UNLOCK_TICKS)) |=> !locked);

  a_r6_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && meas_err >= ERR_W'(LOCK_TICKS) && meas_err <= ERR_W'(UNLOCK_TICKS))
      |=> $stable(locked));

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |-> !lock_out);

  a_r8_powerdown_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !lock_out);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en || pwr_down) |=> !locked);
endmodule

bind pll_lock_detect pll_lock_checker #(
  .ERR_W(ERR_W), .LOCK_TICKS(LOCK_TICKS), .UNLOCK_TICKS(UNLOCK_TICKS),
  .TIMEOUT_TICKS(TIMEOUT_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .pwr_down(pwr_down),
  .lock_out(lock_out), .meas_valid(meas_valid), .meas_err(meas_err),
  .eval_fire(eval_fire), .locked(locked)
);

// File: tb/sim_pll_lock_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_detect;
  localparam int LK = 4, UNL = 8, GR = 4, EV = 4, TMO = 20;
  localparam int PERIOD = 48, HIGH = 16;

  logic clk = 0, rst_n = 0, ref_in = 0, fb_in = 0, lock_en = 0, pwr_down = 0;
  wire  lock_out;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_good = 0;
  bit m_lk = 0, done = 0;

  always #4 clk = ~clk;

  pll_lock_detect #(.LOCK_TICKS(LK), .UNLOCK_TICKS(UNL), .GOOD_RUN(GR),
    .EVAL_PERIOD(EV), .TIMEOUT_TICKS(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .lock_en(lock_en), .pwr_down(pwr_down), .lock_out(lock_out));

  task automatic check(string tag);
    bit exp = m_lk && lock_en && !pwr_down;
    checks++;
    if (lock_out !== exp) begin
      fails++;
      $display("FAIL %s: lock_out=%0b expected %0b", tag, lock_out, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_good = 0; m_lk = 0;
  endtask

  task automatic model_meas(int e);
    m_cnt++;
    if (m_cnt == EV) begin
      m_cnt = 0;
      if (e > UNL) begin m_lk = 0; m_good = 0; end
      else if (e < LK) begin
        if (m_good < GR) m_good++;
        if (m_good >= GR) m_lk = 1;
      end else m_good = 0;
    end
  endtask

  task automatic set_ctrl(bit en, bit pd, string tag);
    @(negedge clk);
    lock_en = en; pwr_down = pd;
    if (!(en && !pd)) model_clear();
    #1 check(tag);
  endtask

  // one reference cycle; d>0 fb lags, d<0 fb leads; miss_fb: fb never rises
  task automatic run_cycle(int d, bit miss_fb, string tag);
    int rt = (d < 0) ? -d : 0;
    int ft = (d < 0) ? 0 : d;
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      ref_in = (c >= rt && c < rt + HIGH);
      fb_in  = !miss_fb && (c >= ft && c < ft + HIGH);
    end
    if (lock_en && !pwr_down) model_meas(miss_fb ? TMO : ((d < 0) ? -d : d));
    else model_clear();
    #1 check(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R9 reset");
    rst_n = 1;
    set_ctrl(1, 0, "R9 after reset");

    // sweep every offset through each threshold band
    for (int d = -12; d <= 12; d++) begin
      int a = (d < 0) ? -d : d;
      string tag = (a < LK) ? "R1 R4" : ((a > UNL) ? "R1 R5" : "R1 R6");
      set_ctrl(0, 0, "R7 clear");
      set_ctrl(1, 0, "R7 reenable");
      for (int k = 0; k < GR * EV; k++) run_cycle(1, 0, "R4 acquire");
      for (int k = 0; k < 2 * GR * EV; k++) run_cycle(d, 0, tag);
    end

    // only every EV-th measurement counts; timeout saturates above UNL
    set_ctrl(0, 0, "R7 clear");
    set_ctrl(1, 0, "R7 reenable");
    for (int k = 0; k < GR * EV; k++) run_cycle(0, 0, "R4 acquire");
    for (int k = 0; k < EV - 1; k++) run_cycle(12, 0, "R3 skipped");
    run_cycle(0, 1, "R2 timeout drops");

    // middle band restarts the run
    for (int k = 0; k < (GR - 1) * EV; k++) run_cycle(2, 0, "R4 partial");
    for (int k = 0; k < EV; k++) run_cycle(6, 0, "R6 band");
    for (int k = 0; k < (GR - 1) * EV; k++) run_cycle(2, 0, "R6 run restarted");
    for (int k = 0; k < EV; k++) run_cycle(2, 0, "R4 lock");

    // enable and power-down drop a held lock
    set_ctrl(0, 0, "R7 disable");
    set_ctrl(1, 0, "R7 relock needed");
    for (int k = 0; k < GR * EV; k++) run_cycle(1, 0, "R4 reacquire");
    set_ctrl(1, 1, "R8 powerdown");
    set_ctrl(1, 0, "R8 relock needed");

    // clear coincides with the completing evaluation
    for (int k = 0; k < GR * EV - 1; k++) run_cycle(1, 0, "R10 build");
    pwr_down = 1;
    run_cycle(1, 0, "R10 clear wins");
    set_ctrl(1, 0, "R10 release");
    for (int k = 0; k < GR * EV - 1; k++) run_cycle(1, 0, "R10 from scratch");
    run_cycle(1, 0, "R10 relocked");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule